// File: doc/BRIEF.md
# Shared Mailbox RAM Access Arbiter

This block is the message store that sits between a host processor and a CAN protocol engine. It keeps 48 sixteen-bit words in one array, grouped into 32-bit locations. Each port sees a 6-bit halfword address. Bits 5 to 1 of the address pick the 32-bit location and bit 0 picks the half: 0 is the lower half and 1 is the upper half. The array is split into six mailboxes of eight halfwords each. For every port the block also decodes which mailbox the current address falls in, and the direction class of that mailbox.

Each port issues requests with a valid/ready handshake. A request is taken in the cycle where valid and ready are both high. The requester must hold valid and all request fields steady until that cycle. A cycle in which valid is high and ready is low is a wait state. Read responses come back one cycle after acceptance, flagged by a single-cycle rvalid pulse. The response channel has no back-pressure, so the requester must take the data in that cycle.

The protocol engine is served first. Its reads and writes take one cycle. A host read also takes one cycle when the engine is idle. A host write is done as a read-modify-write of the full 32-bit location and spans two cycles. The first cycle captures the location and shows one wait state. The second cycle writes back the merged word, and ready is high in that cycle. During the write-back cycle, an engine write to the same 32-bit location is held off for one cycle. Engine writes to other locations and engine reads still go through in that cycle.

Top module: `mbx_shared_ram`

## Requirements
- R1: Both ports address the same storage of 48 sixteen-bit words: data written through either port is read back through either port.
- R2: Address bits 5..1 select the 32-bit location and bit 0 selects the half (0 lower, 1 upper); writing one half leaves the other half of the location unchanged.
- R3: An engine request with can_ready high completes in that cycle; a read's data appears on can_rdata with can_rvalid high in the following cycle, and can_rvalid is never high otherwise.
- R4: A host read accepted while the engine is idle completes in that cycle; its data appears on cpu_rdata with cpu_rvalid high in the following cycle.
- R5: A host write that meets an idle engine sees exactly one wait cycle (cpu_ready low), then cpu_ready is high in the commit cycle; after the commit the written value reads back.
- R6: When both ports request in the same cycle the engine is served and the host request is held with cpu_ready low for every such cycle.
- R7: In the commit cycle of a host write, an engine write to the same 32-bit location sees can_ready low and completes in the next cycle, so neither half's update is lost; engine writes to other locations are not held off.
- R8: Mailbox decode per port: index = address bits 5..3; out-of-range flag high for addresses 48..63; class 0 = receive-only (mailboxes 0, 1), 1 = direction selectable (2, 3), 2 = transmit-only (4, 5), 3 = out of range.
- R9: Writes to addresses 48..63 are ignored and reads there return 0; in-range contents are not disturbed.
- R10: After reset every word reads 0, both rvalid outputs are low, and cpu_ready is high while no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | Host request valid |
| cpu_ready | output | 1 | Host request accepted this cycle; low means wait state |
| cpu_we | input | 1 | Host request is a write |
| cpu_addr | input | 6 | Host halfword address |
| cpu_wdata | input | 16 | Host write data |
| cpu_rvalid | output | 1 | Host read data valid |
| cpu_rdata | output | 16 | Host read data |
| cpu_mbx_idx | output | 3 | Mailbox index of cpu_addr |
| cpu_mbx_class | output | 2 | Direction class of that mailbox |
| cpu_mbx_oor | output | 1 | cpu_addr beyond the array |
| can_valid | input | 1 | Engine request valid |
| can_ready | output | 1 | Engine request accepted this cycle |
| can_we | input | 1 | Engine request is a write |
| can_addr | input | 6 | Engine halfword address |
| can_wdata | input | 16 | Engine write data |
| can_rvalid | output | 1 | Engine read data valid |
| can_rdata | output | 16 | Engine read data |
| can_mbx_idx | output | 3 | Mailbox index of can_addr |
| can_mbx_class | output | 2 | Direction class of that mailbox |
| can_mbx_oor | output | 1 | can_addr beyond the array |

## Verification
Some properties are checked on every cycle. These are the handshake timing properties: the single wait state and the commit that follows it on host writes, engine priority over host reads, next-cycle rvalid after each accepted read, the hold-off of a same-location engine write during a commit, and the consistency of the mailbox decode. Other behaviour depends on data values, so only the bench scenarios can show it. These are that data written on one port reads back on the other, that half-location writes keep the neighbouring half, that the two halves written in a contended commit both survive, that out-of-range writes leave storage untouched, and that back-to-back engine traffic holds the host for exactly the right number of cycles.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    MBX_RX_ONLY = 2'd0,
    MBX_SELECT  = 2'd1,
    MBX_TX_ONLY = 2'd2,
    MBX_NONE    = 2'd3
  } mbx_class_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int ADDR_W    = 6,
  parameter int WORDS     = 48,
  parameter int MBX_WORDS = 8,
  parameter int RX_N      = 2,
  parameter int SEL_N     = 2,
  localparam int IDX_W    = ADDR_W - $clog2(MBX_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [1:0]        cls,
  output logic              oor
);
  import mbx_pkg::*;

  localparam int SHIFT = $clog2(MBX_WORDS);
  localparam logic [ADDR_W:0] WORDS_L = (ADDR_W+1)'(WORDS);
  localparam logic [IDX_W:0]  RX_L    = (IDX_W+1)'(RX_N);
  localparam logic [IDX_W:0]  SEL_L   = (IDX_W+1)'(RX_N + SEL_N);

  mbx_class_e cls_e;

  assign idx = addr[ADDR_W-1:SHIFT];
  assign oor = ({1'b0, addr} >= WORDS_L);

  always_comb begin
    if (oor)                     cls_e = MBX_NONE;
    else if ({1'b0, idx} < RX_L)  cls_e = MBX_RX_ONLY;
    else if ({1'b0, idx} < SEL_L) cls_e = MBX_SELECT;
    else                         cls_e = MBX_TX_ONLY;
  end

  assign cls = cls_e;
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int DW    = 16,
  parameter int LOC_W = 5,
  parameter int LOCS  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_rd_en,
  input  logic [LOC_W-1:0] a_loc,
  input  logic             a_hi,
  output logic [DW-1:0]    a_rdata,
  input  logic             b_rd_en,
  input  logic [LOC_W-1:0] b_loc,
  input  logic             b_hi,
  output logic [DW-1:0]    b_rdata,
  input  logic [LOC_W-1:0] peek_loc,
  output logic [2*DW-1:0]  peek_word,
  input  logic             c_en,
  input  logic [LOC_W-1:0] c_loc,
  input  logic [2*DW-1:0]  c_word,
  input  logic             w_en,
  input  logic [LOC_W-1:0] w_loc,
  input  logic             w_hi,
  input  logic [DW-1:0]    w_data
);
  localparam logic [LOC_W:0] LOCS_L = (LOC_W+1)'(LOCS);

  logic [2*DW-1:0] cells [LOCS];

  for (genvar i = 0; i < LOCS; i++) begin : g_loc
    logic [2*DW-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= '0;
      end else if (c_en && c_loc == LOC_W'(i)) begin
        cell_q <= c_word;
      end else if (w_en && w_loc == LOC_W'(i)) begin
        if (w_hi) cell_q[2*DW-1:DW] <= w_data;
        else      cell_q[DW-1:0]    <= w_data;
      end
    end
    assign cells[i] = cell_q;
  end

  function automatic logic [2*DW-1:0] fetch(input logic [LOC_W-1:0] loc);
    if ({1'b0, loc} < LOCS_L) return cells[loc];
    return '0;
  endfunction

  logic [2*DW-1:0] a_word, b_word;
  assign a_word    = fetch(a_loc);
  assign b_word    = fetch(b_loc);
  assign peek_word = fetch(peek_loc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd_en) a_rdata <= a_hi ? a_word[2*DW-1:DW] : a_word[DW-1:0];
      if (b_rd_en) b_rdata <= b_hi ? b_word[2*DW-1:DW] : b_word[DW-1:0];
    end
  end
endmodule

// File: rtl/mbx_arbiter.sv
module mbx_arbiter #(
  parameter int DW    = 16,
  parameter int LOC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic             cpu_we,
  input  logic [LOC_W-1:0] cpu_loc,
  input  logic             cpu_hi,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic [2*DW-1:0]  peek_word,
  input  logic             can_valid,
  input  logic             can_we,
  input  logic [LOC_W-1:0] can_loc,
  output logic             cpu_ready,
  output logic             cpu_rd_go,
  output logic             can_ready,
  output logic             can_go,
  output logic             commit_en,
  output logic [LOC_W-1:0] commit_loc,
  output logic [2*DW-1:0]  commit_word
);
  logic             busy_q;
  logic [LOC_W-1:0] loc_q;
  logic             hi_q;
  logic [DW-1:0]    wd_q;
  logic [2*DW-1:0]  word_q;
  logic             start;

  assign start     = !busy_q && cpu_valid && cpu_we && !can_valid;
  assign cpu_ready = busy_q || (!cpu_we && !can_valid);
  assign cpu_rd_go = cpu_valid && !cpu_we && !can_valid && !busy_q;
  assign can_ready = !(busy_q && can_we && can_loc == loc_q);
  assign can_go    = can_valid && can_ready;

  assign commit_en   = busy_q;
  assign commit_loc  = loc_q;
  assign commit_word = hi_q ? {wd_q, word_q[DW-1:0]} : {word_q[2*DW-1:DW], wd_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      loc_q  <= '0;
      hi_q   <= 1'b0;
      wd_q   <= '0;
      word_q <= '0;
    end else begin
      busy_q <= start;
      if (start) begin
        loc_q  <= cpu_loc;
        hi_q   <= cpu_hi;
        wd_q   <= cpu_wdata;
        word_q <= peek_word;
      end
    end
  end
endmodule

// File: rtl/mbx_shared_ram.sv
module mbx_shared_ram #(
  parameter int ADDR_W    = 6,
  parameter int DW        = 16,
  parameter int WORDS     = 48,
  parameter int MBX_WORDS = 8,
  parameter int RX_N      = 2,
  parameter int SEL_N     = 2,
  localparam int LOC_W    = ADDR_W - 1,
  localparam int LOCS     = WORDS / 2,
  localparam int IDX_W    = ADDR_W - $clog2(MBX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic              cpu_rvalid,
  output logic [DW-1:0]     cpu_rdata,
  output logic [IDX_W-1:0]  cpu_mbx_idx,
  output logic [1:0]        cpu_mbx_class,
  output logic              cpu_mbx_oor,
  input  logic              can_valid,
  output logic              can_ready,
  input  logic              can_we,
  input  logic [ADDR_W-1:0] can_addr,
  input  logic [DW-1:0]     can_wdata,
  output logic              can_rvalid,
  output logic [DW-1:0]     can_rdata,
  output logic [IDX_W-1:0]  can_mbx_idx,
  output logic [1:0]        can_mbx_class,
  output logic              can_mbx_oor
);
  logic             cpu_rd_go, can_go, commit_en;
  logic [LOC_W-1:0] commit_loc;
  logic [2*DW-1:0]  commit_word, peek_word;

  mbx_decode #(.ADDR_W(ADDR_W), .WORDS(WORDS), .MBX_WORDS(MBX_WORDS),
               .RX_N(RX_N), .SEL_N(SEL_N)) u_dec_cpu (
    .addr(cpu_addr), .idx(cpu_mbx_idx), .cls(cpu_mbx_class), .oor(cpu_mbx_oor));

  mbx_decode #(.ADDR_W(ADDR_W), .WORDS(WORDS), .MBX_WORDS(MBX_WORDS),
               .RX_N(RX_N), .SEL_N(SEL_N)) u_dec_can (
    .addr(can_addr), .idx(can_mbx_idx), .cls(can_mbx_class), .oor(can_mbx_oor));

  mbx_arbiter #(.DW(DW), .LOC_W(LOC_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_loc(cpu_addr[ADDR_W-1:1]),
    .cpu_hi(cpu_addr[0]), .cpu_wdata(cpu_wdata), .peek_word(peek_word),
    .can_valid(can_valid), .can_we(can_we), .can_loc(can_addr[ADDR_W-1:1]),
    .cpu_ready(cpu_ready), .cpu_rd_go(cpu_rd_go),
    .can_ready(can_ready), .can_go(can_go),
    .commit_en(commit_en), .commit_loc(commit_loc), .commit_word(commit_word));

  mbx_store #(.DW(DW), .LOC_W(LOC_W), .LOCS(LOCS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_rd_en(cpu_rd_go), .a_loc(cpu_addr[ADDR_W-1:1]), .a_hi(cpu_addr[0]),
    .a_rdata(cpu_rdata),
    .b_rd_en(can_go && !can_we), .b_loc(can_addr[ADDR_W-1:1]), .b_hi(can_addr[0]),
    .b_rdata(can_rdata),
    .peek_loc(cpu_addr[ADDR_W-1:1]), .peek_word(peek_word),
    .c_en(commit_en), .c_loc(commit_loc), .c_word(commit_word),
    .w_en(can_go && can_we), .w_loc(can_addr[ADDR_W-1:1]), .w_hi(can_addr[0]),
    .w_data(can_wdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rvalid <= 1'b0;
      can_rvalid <= 1'b0;
    end else begin
      cpu_rvalid <= cpu_rd_go;
      can_rvalid <= can_go && !can_we;
    end
  end
endmodule

// File: rtl/mbx_shared_ram_chk.sv
module mbx_shared_ram_chk #(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 3,
  parameter int NUM_MBX = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rvalid,
  input logic [IDX_W-1:0]  cpu_mbx_idx,
  input logic [1:0]        cpu_mbx_class,
  input logic              cpu_mbx_oor,
  input logic              can_valid,
  input logic              can_ready,
  input logic              can_we,
  input logic [ADDR_W-1:0] can_addr,
  input logic              can_rvalid
);
  localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_MBX);

  // R5
  cpu_wait_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_we && !cpu_ready && !can_valid) |=> cpu_ready);

  // R5
  cpu_commit_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_we && cpu_ready) |-> $past(cpu_valid && cpu_we && !cpu_ready));

  // R6
  can_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_we && can_valid) |-> !cpu_ready);

  // R3
  can_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (can_valid && can_ready && !can_we) |=> can_rvalid);

  // R3
  can_rvalid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    can_rvalid |-> $past(can_valid && can_ready && !can_we));

  // R4
  cpu_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && !cpu_we) |=> cpu_rvalid);

  // R7
  same_loc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cpu_valid && cpu_we && !cpu_ready && !can_valid) &&
     cpu_valid && cpu_we && can_valid && can_we &&
     can_addr[ADDR_W-1:1] == cpu_addr[ADDR_W-1:1]) |-> !can_ready);

  // R8
  decode_oor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_mbx_oor |-> cpu_mbx_class == 2'd3);

  // R8
  decode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_mbx_oor |-> ({1'b0, cpu_mbx_idx} < NUM_L && cpu_mbx_class != 2'd3));
endmodule

bind mbx_shared_ram mbx_shared_ram_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_rvalid(cpu_rvalid), .cpu_mbx_idx(cpu_mbx_idx), .cpu_mbx_class(cpu_mbx_class),
  .cpu_mbx_oor(cpu_mbx_oor),
  .can_valid(can_valid), .can_ready(can_ready), .can_we(can_we), .can_addr(can_addr),
  .can_rvalid(can_rvalid));

// File: tb/mbx_shared_ram_tb.sv
module mbx_shared_ram_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 0, cpu_we = 0, can_valid = 0, can_we = 0;
  logic [5:0]  cpu_addr = '0, can_addr = '0;
  logic [15:0] cpu_wdata = '0, can_wdata = '0;
  logic cpu_ready, cpu_rvalid, cpu_mbx_oor, can_ready, can_rvalid, can_mbx_oor;
  logic [15:0] cpu_rdata, can_rdata;
  logic [2:0]  cpu_mbx_idx, can_mbx_idx;
  logic [1:0]  cpu_mbx_class, can_mbx_class;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [64];
  logic [15:0] cpu_q[$], can_q[$];
  string cpu_tag[$], can_tag[$];

  always #2 clk = ~clk;

  mbx_shared_ram u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mread(input logic [5:0] a);
    return (a < 6'd48) ? model[a] : 16'h0000;
  endfunction

  // caller is at a falling edge; returns at a later falling edge with valid cleared
  task automatic cpu_op(input bit we, input logic [5:0] a, input logic [15:0] d,
                        output int waits, input string tag);
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; waits = 0; #1;
    while (!cpu_ready) begin waits++; @(negedge clk); #1; end
    if (!we) begin cpu_q.push_back(mread(a)); cpu_tag.push_back(tag); end
    else if (a < 6'd48) model[a] = d;
    @(negedge clk); cpu_valid = 0; cpu_we = 0;
  endtask

  task automatic can_op(input bit we, input logic [5:0] a, input logic [15:0] d,
                        output int waits, input string tag);
    can_valid = 1; can_we = we; can_addr = a; can_wdata = d; waits = 0; #1;
    while (!can_ready) begin waits++; @(negedge clk); #1; end
    if (!we) begin can_q.push_back(mread(a)); can_tag.push_back(tag); end
    else if (a < 6'd48) model[a] = d;
    @(negedge clk); can_valid = 0; can_we = 0;
  endtask

  // scoreboard monitors
  always @(negedge clk) begin
    if (rst_n && cpu_rvalid) begin
      if (cpu_q.size() == 0) chk(0, "R4 unexpected cpu_rvalid", 1, 0);
      else begin
        logic [15:0] e; string t;
        e = cpu_q.pop_front(); t = cpu_tag.pop_front();
        chk(cpu_rdata == e, t, cpu_rdata, e);
      end
    end
    if (rst_n && can_rvalid) begin
      if (can_q.size() == 0) chk(0, "R3 unexpected can_rvalid", 1, 0);
      else begin
        logic [15:0] e; string t;
        e = can_q.pop_front(); t = can_tag.pop_front();
        chk(can_rdata == e, t, can_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w, w2;
    for (int i = 0; i < 64; i++) model[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R10 reset state
    chk(cpu_rvalid == 0 && can_rvalid == 0, "R10 rvalid low after reset", {cpu_rvalid, can_rvalid}, 0);
    chk(cpu_ready == 1, "R10 cpu_ready idle", cpu_ready, 1);
    @(negedge clk);
    cpu_op(0, 6'd0, 0, w, "R10 word reads zero after reset");
    can_op(0, 6'd47, 0, w, "R10 last word reads zero after reset");

    // R5 single wait, R1/R2 readback
    cpu_op(1, 6'd4, 16'hA5A5, w, "R5");
    chk(w == 1, "R5 one wait on host write", w, 1);
    cpu_op(1, 6'd5, 16'h1234, w, "R5");
    chk(w == 1, "R5 one wait on upper half write", w, 1);
    cpu_op(0, 6'd4, 0, w, "R2 lower half kept after upper write");
    chk(w == 0, "R4 host read no wait", w, 0);
    cpu_op(0, 6'd5, 0, w, "R5 written value reads back");
    can_op(0, 6'd4, 0, w, "R1 engine sees host data");
    can_op(1, 6'd20, 16'hBEEF, w, "R3");
    chk(w == 0, "R3 engine write no wait", w, 0);
    cpu_op(0, 6'd20, 0, w, "R1 host sees engine data");
    cpu_op(1, 6'd21, 16'h7777, w, "R2");
    can_op(0, 6'd20, 0, w, "R2 engine half kept after host upper write");
    can_op(0, 6'd21, 0, w, "R2 host upper half");

    // R1 sweep: alternate writers, read through the other port
    for (int i = 0; i < 48; i++) begin
      if (i % 2 == 0) cpu_op(1, 6'(i), 16'(i * 16'h0101 + 16'h3C), w, "R1");
      else            can_op(1, 6'(i), 16'(16'hF000 - i * 7), w, "R1");
    end
    for (int i = 0; i < 48; i++) begin
      if (i % 2 == 0) can_op(0, 6'(i), 0, w, "R1 sweep engine readback");
      else            cpu_op(0, 6'(i), 0, w, "R1 sweep host readback");
    end

    // R6 engine priority: three engine reads hold a host read
    fork
      begin
        can_op(0, 6'd1, 0, w2, "R6 engine read 1");
        can_op(0, 6'd2, 0, w2, "R6 engine read 2");
        can_op(0, 6'd3, 0, w2, "R6 engine read 3");
      end
      cpu_op(0, 6'd7, 0, w, "R6 held host read data");
    join
    chk(w == 3, "R6 host held for three engine cycles", w, 3);
    // R6 host write held one cycle by engine write, then its own wait
    fork
      can_op(1, 6'd30, 16'h5A5A, w2, "R6");
      cpu_op(1, 6'd31, 16'h6B6B, w, "R6");
    join
    chk(w == 2, "R6 host write waits engine cycle plus wait state", w, 2);
    chk(w2 == 0, "R6 engine not delayed", w2, 0);
    cpu_op(0, 6'd30, 0, w, "R6 engine half after contention");
    cpu_op(0, 6'd31, 0, w, "R6 host half after contention");

    // R7 same-location engine write during commit
    cpu_valid = 1; cpu_we = 1; cpu_addr = 6'd10; cpu_wdata = 16'hC0DE; #1;
    chk(cpu_ready == 0, "R7 wait cycle", cpu_ready, 0);
    @(negedge clk);
    can_valid = 1; can_we = 1; can_addr = 6'd11; can_wdata = 16'hF00D; #1;
    chk(can_ready == 0, "R7 engine held in commit cycle", can_ready, 0);
    chk(cpu_ready == 1, "R5 commit cycle ready", cpu_ready, 1);
    @(negedge clk);
    cpu_valid = 0; cpu_we = 0; model[10] = 16'hC0DE; #1;
    chk(can_ready == 1, "R7 engine released after commit", can_ready, 1);
    @(negedge clk);
    can_valid = 0; can_we = 0; model[11] = 16'hF00D;
    cpu_op(0, 6'd10, 0, w, "R7 host half survives");
    cpu_op(0, 6'd11, 0, w, "R7 engine half survives");

    // R7 other location not blocked
    cpu_valid = 1; cpu_we = 1; cpu_addr = 6'd12; cpu_wdata = 16'h1111; #1;
    @(negedge clk);
    can_valid = 1; can_we = 1; can_addr = 6'd40; can_wdata = 16'h2222; #1;
    chk(can_ready == 1, "R7 other location not held", can_ready, 1);
    @(negedge clk);
    cpu_valid = 0; cpu_we = 0; can_valid = 0; can_we = 0;
    model[12] = 16'h1111; model[40] = 16'h2222;
    can_op(0, 6'd12, 0, w, "R7 host write with parallel engine write");
    cpu_op(0, 6'd40, 0, w, "R7 parallel engine write");

    // R9 out of range
    cpu_op(1, 6'd50, 16'h1357, w, "R9");
    can_op(1, 6'd60, 16'h2468, w, "R9");
    cpu_op(0, 6'd50, 0, w, "R9 host read beyond array is zero");
    can_op(0, 6'd60, 0, w, "R9 engine read beyond array is zero");
    cpu_op(0, 6'd2, 0, w, "R9 in-range word undisturbed");
    cpu_op(0, 6'd12, 0, w, "R9 in-range word undisturbed");

    // R8 decode
    for (int a = 0; a < 64; a++) begin
      logic [1:0] ec;
      cpu_addr = 6'(a); can_addr = 6'(63 - a); #1;
      ec = (a >= 48) ? 2'd3 : (a < 16) ? 2'd0 : (a < 32) ? 2'd1 : 2'd2;
      chk(cpu_mbx_idx == 3'(a >> 3), "R8 host index", cpu_mbx_idx, a >> 3);
      chk(cpu_mbx_oor == (a >= 48), "R8 host range flag", cpu_mbx_oor, a >= 48);
      chk(cpu_mbx_class == ec, "R8 host class", cpu_mbx_class, ec);
      chk(can_mbx_idx == 3'((63 - a) >> 3), "R8 engine index", can_mbx_idx, (63 - a) >> 3);
      @(negedge clk);
    end

    repeat (4) @(negedge clk);
    chk(cpu_q.size() == 0 && can_q.size() == 0, "R3 R4 all reads answered",
        cpu_q.size() + can_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule